// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial audio stream into parallel samples. It acts as a slave on an external bit clock and frame clock. It samples both clocks and the serial data line with a faster system clock, then finds the clock edges inside the system clock domain. One configuration input picks the framing: I2S, left-justified or right-justified. A second input picks the sample width.

Each time a left word and then a right word have been received, the block shows the pair on two parallel outputs. It raises a valid strobe for one system cycle at the same moment. Words are returned right-aligned in the output bus and the bits above the selected width are zero. Both outputs hold their values until the next strobe. Frame-clock and bit-clock generation, transmission and any signal processing are left to other blocks.

Top module: `ser_audio_rx`

## Requirements
- R1: While reset is high, `left_out` and `right_out` are cleared to zero and `frame_valid` is low on the following cycle.
- R2: With `fmt_sel` = 2'b01 (left-justified), the MSB is taken on the first bit-clock rise after a frame-clock change, and the next N-1 rises supply the remaining bits, MSB first.
- R3: With `fmt_sel` = 2'b00 (I2S), or the unused code 2'b11, the first bit-clock rise after a frame-clock change is skipped and the MSB is taken on the second rise, then N-1 more bits follow.
- R4: With `fmt_sel` = 2'b10 (right-justified), the word is the last N bits received before a frame-clock change, so the LSB is the bit on the final rise of the half-frame.
- R5: `wlen_sel` sets N as follows: 2'b00 gives 16, 2'b01 gives 20, 2'b10 gives 24 and 2'b11 gives 32, limited to MAX_W. The word appears in bits N-1..0 of the output and all higher bits are zero.
- R6: A high frame clock marks the left channel in the left-justified and right-justified modes. A low frame clock marks the left channel in I2S mode.
- R7: In the left-justified and I2S modes, bits that fall outside the N-bit window of a half-frame have no effect on the outputs. In right-justified mode, bits sent before the final N have no effect.
- R8: `frame_valid` is high for exactly one system cycle when a right word completes. `left_out` and `right_out` change only in that cycle.
- R9: A right word produces a strobe only if a left word has completed since the last strobe. A right word with no left word before it is dropped and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | External bit clock (asynchronous) |
| lrclk_in | input | 1 | External frame clock, which selects the channel (asynchronous) |
| sdata_in | input | 1 | Serial data, MSB first, changes on falling bit-clock edges |
| fmt_sel | input | 2 | Framing: 00 I2S, 01 left-justified, 10 right-justified, 11 treated as I2S |
| wlen_sel | input | 2 | Word length code (16/20/24/32 bits) |
| left_out | output | MAX_W | Last completed left sample, right-aligned |
| right_out | output | MAX_W | Last completed right sample, right-aligned |
| frame_valid | output | 1 | One-cycle strobe when a new stereo pair is on the outputs |

## Verification
The assertions take the following for granted:
- `fmt_sel` and `wlen_sel` change only during reset.
- The bit clock stays low and high for at least two system cycles in each phase.
- Data and the frame clock change only on the falling bit-clock edge.
- Every half-frame has at least N+1 bit clocks in I2S mode and at least N in the other modes.

The stimulus keeps to these limits. It uses a 34-bit slot with eight system cycles per bit-clock phase, and it changes the configuration only while reset is held. Random bits fill the slot positions outside the data window. Each configuration starts with a right half-frame that has no left half-frame before it.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

  // Word length code to bit count, clipped to the bus width.
  function automatic int unsigned wl_bits(input logic [1:0] code, input int unsigned maxw);
    int unsigned r;
    case (code)
      2'b00:   r = 16;
      2'b01:   r = 20;
      2'b10:   r = 24;
      default: r = 32;
    endcase
    if (r > maxw) r = maxw;
    return r;
  endfunction

  // Frame clock level that marks the left channel depends on the framing.
  function automatic logic is_left(input fmt_e f, input logic lr);
    return (f == FMT_LJ || f == FMT_RJ) ? lr : !lr;
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sar_edge.sv
module sar_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic chg
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign chg  = lvl ^ prev;
endmodule

// File: rtl/sar_deser.sv
module sar_deser
  import sar_pkg::*;
#(
  parameter int MAX_W = 32,
  localparam int CW   = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  fmt_e             fmt,
  input  logic [CW-1:0]    nbits,
  input  logic             bit_rise,
  input  logic             lr_lvl,
  input  logic             lr_chg,
  input  logic             din,
  output logic             done,
  output logic             done_left,
  output logic [MAX_W-1:0] word
);
  logic [MAX_W-1:0] sreg;
  logic [MAX_W-1:0] shifted;
  logic [MAX_W-1:0] mask;
  logic [CW-1:0]    ncap;
  logic             skip_done;
  logic             delayed_fmt;
  logic             cap_en;

  assign shifted     = {sreg[MAX_W-2:0], din};
  assign delayed_fmt = (fmt == FMT_I2S) || (fmt == FMT_RSV);

  always_comb begin
    if (nbits >= CW'(MAX_W)) mask = '1;
    else                     mask = (MAX_W'(1) << nbits) - MAX_W'(1);
  end

  // Window capture for the MSB-first-at-start formats.
  assign cap_en = bit_rise && (fmt != FMT_RJ) && (ncap < nbits) &&
                  (!delayed_fmt || skip_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg      <= '0;
      ncap      <= '0;
      skip_done <= 1'b0;
      done      <= 1'b0;
      done_left <= 1'b0;
      word      <= '0;
    end else begin
      done <= 1'b0;
      if (lr_chg) begin
        sreg      <= '0;
        ncap      <= '0;
        skip_done <= 1'b0;
        if (fmt == FMT_RJ) begin
          // Half-frame just ended: its channel is the previous level.
          done      <= 1'b1;
          done_left <= is_left(fmt, !lr_lvl);
          word      <= sreg & mask;
        end
      end else if (bit_rise) begin
        if (fmt == FMT_RJ) begin
          sreg <= shifted;
        end else begin
          skip_done <= 1'b1;
          if (cap_en) begin
            sreg <= shifted;
            ncap <= ncap + CW'(1);
            if (ncap == nbits - CW'(1)) begin
              done      <= 1'b1;
              done_left <= is_left(fmt, lr_lvl);
              word      <= shifted;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import sar_pkg::*;
#(
  parameter int MAX_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_in,
  input  logic             lrclk_in,
  input  logic             sdata_in,
  input  logic [1:0]       fmt_sel,
  input  logic [1:0]       wlen_sel,
  output logic [MAX_W-1:0] left_out,
  output logic [MAX_W-1:0] right_out,
  output logic             frame_valid
);
  localparam int CW = $clog2(MAX_W + 1);

  logic [2:0]       raw, syn;
  logic             bit_rise, bit_chg_unused, lr_rise_unused, lr_chg;
  logic [CW-1:0]    nbits;
  logic             done, done_left;
  logic [MAX_W-1:0] word;
  logic [MAX_W-1:0] pend_l;
  logic             have_left;

  assign raw   = {sdata_in, lrclk_in, bclk_in};
  assign nbits = CW'(wl_bits(wlen_sel, MAX_W));

  sar_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  sar_edge u_bedge (
    .clk(clk), .rst(rst), .lvl(syn[0]), .rise(bit_rise), .chg(bit_chg_unused)
  );

  sar_edge u_ledge (
    .clk(clk), .rst(rst), .lvl(syn[1]), .rise(lr_rise_unused), .chg(lr_chg)
  );

  sar_deser #(.MAX_W(MAX_W)) u_deser (
    .clk(clk), .rst(rst), .fmt(fmt_e'(fmt_sel)), .nbits(nbits),
    .bit_rise(bit_rise), .lr_lvl(syn[1]), .lr_chg(lr_chg), .din(syn[2]),
    .done(done), .done_left(done_left), .word(word)
  );

  // Pair collector: a right word only publishes after a left one.
  always_ff @(posedge clk) begin
    if (rst) begin
      left_out    <= '0;
      right_out   <= '0;
      frame_valid <= 1'b0;
      pend_l      <= '0;
      have_left   <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (done) begin
        if (done_left) begin
          pend_l    <= word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_out    <= pend_l;
          right_out   <= word;
          frame_valid <= 1'b1;
          have_left   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk
  import sar_pkg::*;
#(
  parameter int MAX_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       wlen_sel,
  input logic [MAX_W-1:0] left_out,
  input logic [MAX_W-1:0] right_out,
  input logic             frame_valid
);
  logic [MAX_W-1:0] ck_mask;
  int unsigned      ck_n;

  always_comb begin
    ck_n = wl_bits(wlen_sel, MAX_W);
    if (ck_n >= MAX_W) ck_mask = '1;
    else               ck_mask = (MAX_W'(1) << ck_n) - MAX_W'(1);
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!frame_valid && left_out == '0 && right_out == '0));

  // R8
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R8
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> ($stable(left_out) && $stable(right_out)));

  // R5
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ((left_out | right_out) & ~ck_mask) == '0);
endmodule

bind ser_audio_rx sar_rx_chk #(.MAX_W(MAX_W)) u_chk (
  .clk(clk), .rst(rst), .wlen_sel(wlen_sel), .left_out(left_out),
  .right_out(right_out), .frame_valid(frame_valid)
);

// File: tb/sim_ser_audio_rx.sv
module sim_ser_audio_rx;
  localparam int MAX_W = 32;
  localparam int SLOT  = 34;
  localparam int PH    = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bclk_in = 1'b1, lrclk_in = 1'b0, sdata_in = 1'b0;
  logic [1:0]       fmt_sel = 2'b00, wlen_sel = 2'b00;
  logic [MAX_W-1:0] left_out, right_out;
  logic             frame_valid;

  int    n_run = 0, n_fail = 0, n_strobe = 0;
  bit    finished = 0;
  bit    prev_valid = 0;
  string cur_tag = "R3";
  logic [MAX_W-1:0] q_l[$], q_r[$];

  always #2 clk = ~clk;

  ser_audio_rx #(.MAX_W(MAX_W)) u0 (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
    .sdata_in(sdata_in), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
    .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
  );

  task automatic check(input bit ok, input string tag, input logic [MAX_W-1:0] act,
                       input logic [MAX_W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] c);
    case (c)
      2'b00:   return 16;
      2'b01:   return 20;
      2'b10:   return 24;
      default: return 32;
    endcase
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && frame_valid) begin
      n_strobe++;
      check(!prev_valid, "R8 strobe longer than one cycle", 1, 0);
      if (q_l.size() == 0) begin
        check(0, "R9 strobe with nothing expected", right_out, 0);
      end else begin
        logic [MAX_W-1:0] el, er;
        el = q_l.pop_front();
        er = q_r.pop_front();
        check(left_out == el, {cur_tag, " R6 R7 left word"}, left_out, el);
        check(right_out == er, {cur_tag, " R5 R7 right word"}, right_out, er);
      end
    end
    prev_valid = frame_valid;
  end

  task automatic bit_slot(input logic lr, input logic d);
    @(negedge clk);
    bclk_in  = 1'b0;
    lrclk_in = lr;
    sdata_in = d;
    repeat (PH) @(negedge clk);
    bclk_in = 1'b1;
    repeat (PH - 1) @(negedge clk);
  endtask

  task automatic send_half(input logic [1:0] f, input int n, input logic [MAX_W-1:0] w,
                           input logic lr);
    for (int k = 0; k < SLOT; k++) begin
      logic d;
      d = 1'($urandom % 2);
      if (f == 2'b01) begin
        if (k < n) d = w[n-1-k];
      end else if (f == 2'b10) begin
        if (k >= SLOT - n) d = w[SLOT-1-k];
      end else begin
        if (k >= 1 && k <= n) d = w[n-k];
      end
      bit_slot(lr, d);
    end
  endtask

  task automatic run_cfg(input logic [1:0] f, input logic [1:0] wc, input string tag,
                         input bit chk_reset);
    int n;
    logic lft, base;
    logic [MAX_W-1:0] m;
    n    = nbits_of(wc);
    m    = (n >= MAX_W) ? '1 : ((MAX_W'(1) << n) - 1);
    lft  = (f == 2'b01 || f == 2'b10) ? 1'b1 : 1'b0;
    @(negedge clk);
    rst = 1'b1;
    fmt_sel = f;
    wlen_sel = wc;
    bclk_in = 1'b1;
    lrclk_in = ~lft;
    repeat (6) @(negedge clk);
    if (chk_reset) begin
      check(left_out == '0 && right_out == '0, "R1 reset outputs", left_out | right_out, '0);
      check(frame_valid == 1'b0, "R1 reset strobe", MAX_W'(frame_valid), '0);
    end
    rst = 1'b0;
    cur_tag = tag;
    base = 1'b0;
    repeat (4) @(negedge clk);
    n_strobe = 0;
    // Orphan right half-frame: must not produce a strobe (R9).
    send_half(f, n, MAX_W'($urandom), ~lft);
    for (int fr = 0; fr < 2; fr++) begin
      logic [MAX_W-1:0] wl, wr;
      wl = MAX_W'($urandom);
      wr = MAX_W'($urandom);
      if (fr == 0) begin
        wl = ~base;
        wr = '0;
        wr[n-1] = 1'b1;
      end
      q_l.push_back(wl & m);
      q_r.push_back(wr & m);
      send_half(f, n, wl, lft);
      send_half(f, n, wr, ~lft);
    end
    for (int k = 0; k < 3; k++) bit_slot(lft, 1'b1);
    repeat (20) @(negedge clk);
    check(n_strobe == 2, "R9 strobe count", MAX_W'(n_strobe), 2);
    check(q_l.size() == 0, {tag, " pending expected pairs"}, MAX_W'(q_l.size()), 0);
    q_l.delete();
    q_r.delete();
  endtask

  initial begin
    for (int fi = 0; fi < 3; fi++) begin
      for (int wi = 0; wi < 4; wi++) begin
        logic [1:0] f;
        string t;
        f = (fi == 0) ? 2'b00 : (fi == 1) ? 2'b01 : 2'b10;
        t = (fi == 0) ? "R3" : (fi == 1) ? "R2" : "R4";
        run_cfg(f, 2'(wi), t, (fi == 0 && wi == 0));
      end
    end
    run_cfg(2'b11, 2'b01, "R3 reserved code", 1'b1);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule